// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block takes a 32-bit operand and produces the shifted operand together with the carry that the shift pushes out. Five kinds of shift are supported: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right that passes through the carry flag. The amount comes either from a 5-bit immediate field or from the low byte of a register. A register amount is used as a full 8-bit count. Amounts of zero, exactly 32, and above 32 each give defined results and carries.

The block also drives a carry-valid flag. It tells the surrounding flag logic whether the produced carry should replace the stored carry flag. When the shift leaves the carry untouched, the flag is low and the carry output repeats the incoming carry.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream, through one register stage. A result appears one cycle after it is accepted. While `out_valid` is high and `out_ready` is low, the result holds steady and no new operand is taken. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. Results leave in the order their operands were accepted.

Top module: `barrel_shift_unit`

## Requirements
- R1: With `in_kind` = 0 (logical left) and an effective amount n from 1 to 31, the result is the operand shifted left by n with zeros filled in. The carry is operand bit (32 − n) and carry-valid is 1.
- R2: For a logical right shift (`in_kind` = 1), an arithmetic right shift (2) or a rotate right (3), with an effective amount n from 1 to 31, the result is the shifted or rotated operand. The carry is operand bit (n − 1) and carry-valid is 1.
- R3: With `in_use_reg` = 1 and a logical shift (kind 0 or 1), an amount of exactly 32 gives result 0. The carry is then operand bit 0 for a left shift and operand bit 31 for a right shift. An amount above 32 gives result 0 and carry 0. Carry-valid is 1 in all of these cases.
- R4: With `in_use_reg` = 1, an arithmetic right shift by 32 or more fills every result bit with operand bit 31. The carry equals operand bit 31.
- R5: With `in_use_reg` = 1, an amount of 0 and kind 0 to 3, the result equals the operand, the carry equals `in_carry`, and carry-valid is 0.
- R6: With `in_use_reg` = 1 and a rotate, only `in_amount[4:0]` sets the rotation. If those five bits are 0 but the 8-bit count is nonzero, the result equals the operand, the carry is operand bit 31, and carry-valid is 1.
- R7: With `in_use_reg` = 1, a rotate by a count of 32 or more gives the same result and carry as a rotate by the count's low five bits.
- R8: With `in_kind` = 4, the amount is ignored. The result is the operand shifted right by one with `in_carry` placed in bit 31, the carry is old operand bit 0, and carry-valid is 1.
- R9: With `in_use_reg` = 0, only `in_amount[4:0]` is used. An immediate of 0 with a logical right shift means a shift by 32: result 0 and carry equal to operand bit 31. An immediate of 0 with an arithmetic right shift fills the result with operand bit 31, and the carry equals that bit.
- R10: With `in_use_reg` = 0 and an immediate of 0 for a logical left shift or a rotate, the result equals the operand, the carry equals `in_carry`, and carry-valid is 0.
- R11: A result appears on `out_valid` in the cycle after its operand is accepted. It stays stable while `out_ready` is low. `in_ready` is high exactly when the output stage is empty or `out_ready` is high, and results keep their input order.
- R12: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| in_operand | input | 32 | Value to shift |
| in_kind | input | 3 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| in_amount | input | 8 | Shift amount (immediate uses bits 4:0) |
| in_use_reg | input | 1 | 1: register-sourced 8-bit count, 0: immediate |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_value | output | 32 | Shifted operand |
| out_carry | output | 1 | Shifter carry-out |
| out_carry_valid | output | 1 | Carry-out should replace the carry flag |

## Verification
Directed amounts of 0, 1, 31, 32, 33 and 255 are tried with both amount sources and every shift kind. These separate the zero-amount hold cases, the encoding that treats an immediate 0 as 32, the exact-32 carry, and the above-32 carry. Operands with bit 31 and bit 0 set or clear show which bit ends up as the carry. Rotates by counts such as 36 and 64 confirm that only five bits are used. Random traffic under random output stalls checks ordering and the holding of results against a model that shifts one bit per step.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/bshift_amount_dec.sv
module bshift_amount_dec
  import bshift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = 8,
  parameter int IMM_W = 5
) (
  input  logic [2:0]       kind,
  input  logic [CNT_W-1:0] amount,
  input  logic             use_reg,
  output logic [CNT_W-1:0] count,
  output logic             hold
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

  logic [IMM_W-1:0] imm;
  assign imm = amount[IMM_W-1:0];

  always_comb begin
    count = '0;
    hold  = 1'b0;
    if (kind == SH_RRX) begin
      count = CNT_W'(1);
    end else if (kind > SH_RRX) begin
      hold = 1'b1;
    end else if (use_reg) begin
      count = amount;
      hold  = (amount == '0);
    end else if (imm == '0) begin
      if (kind == SH_LSR || kind == SH_ASR) count = FULL;
      else                                  hold  = 1'b1;
    end else begin
      count = CNT_W'(imm);
    end
  end
endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [2:0]       kind,
  input  logic [CNT_W-1:0] count,
  input  logic             hold,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             cvalid
);
  localparam int LOG_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

  logic [WIDTH:0]          lsl_ext, lsr_ext, asr_ext;
  logic [CNT_W-1:0]        asr_cnt;
  logic [LOG_W-1:0]        rot;
  logic [2*WIDTH-1:0]      dbl;
  logic [WIDTH-1:0]        ror_v;

  assign lsl_ext = {1'b0, a} << count;
  assign lsr_ext = {a, 1'b0} >> count;
  assign asr_cnt = (count > FULL) ? FULL : count;
  assign asr_ext = $signed({a, 1'b0}) >>> asr_cnt;
  assign rot     = count[LOG_W-1:0];
  assign dbl     = {a, a} >> rot;
  assign ror_v   = dbl[WIDTH-1:0];

  always_comb begin
    res    = a;
    cout   = cin;
    cvalid = 1'b0;
    if (!hold) begin
      cvalid = 1'b1;
      unique case (kind)
        SH_LSL: begin res = lsl_ext[WIDTH-1:0]; cout = lsl_ext[WIDTH]; end
        SH_LSR: begin res = lsr_ext[WIDTH:1];   cout = lsr_ext[0];     end
        SH_ASR: begin res = asr_ext[WIDTH:1];   cout = asr_ext[0];     end
        SH_ROR: begin res = ror_v;              cout = ror_v[WIDTH-1]; end
        SH_RRX: begin res = {cin, a[WIDTH-1:1]}; cout = a[0];          end
        default: begin res = a; cout = cin; cvalid = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/bshift_out_stage.sv
module bshift_out_stage #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  output logic             d_ready,
  input  logic [WIDTH-1:0] d_value,
  input  logic             d_carry,
  input  logic             d_cvalid,
  output logic             q_valid,
  input  logic             q_ready,
  output logic [WIDTH-1:0] q_value,
  output logic             q_carry,
  output logic             q_cvalid
);
  assign d_ready = !q_valid || q_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_value  <= '0;
      q_carry  <= 1'b0;
      q_cvalid <= 1'b0;
    end else if (d_ready) begin
      q_valid <= d_valid;
      if (d_valid) begin
        q_value  <= d_value;
        q_carry  <= d_carry;
        q_cvalid <= d_cvalid;
      end
    end
  end

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_ready |=> q_valid && $stable(q_value) && $stable(q_carry) && $stable(q_cvalid));

  // R11
  take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && d_ready |=> q_valid);
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import bshift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = 8,
  parameter int IMM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_operand,
  input  logic [2:0]       in_kind,
  input  logic [CNT_W-1:0] in_amount,
  input  logic             in_use_reg,
  input  logic             in_carry,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_value,
  output logic             out_carry,
  output logic             out_carry_valid
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

  logic [CNT_W-1:0] count;
  logic             hold;
  logic [WIDTH-1:0] res;
  logic             cout, cvalid;

  bshift_amount_dec #(.WIDTH(WIDTH), .CNT_W(CNT_W), .IMM_W(IMM_W)) u_dec (
    .kind(in_kind), .amount(in_amount), .use_reg(in_use_reg),
    .count(count), .hold(hold)
  );

  bshift_core #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_core (
    .a(in_operand), .kind(in_kind), .count(count), .hold(hold), .cin(in_carry),
    .res(res), .cout(cout), .cvalid(cvalid)
  );

  bshift_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst_n(rst_n),
    .d_valid(in_valid), .d_ready(in_ready),
    .d_value(res), .d_carry(cout), .d_cvalid(cvalid),
    .q_valid(out_valid), .q_ready(out_ready),
    .q_value(out_value), .q_carry(out_carry), .q_cvalid(out_carry_valid)
  );

  logic accept;
  assign accept = in_valid && in_ready;

  // R8
  rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_kind == SH_RRX |=>
      out_value == {$past(in_carry), $past(in_operand[WIDTH-1:1])} &&
      out_carry == $past(in_operand[0]) && out_carry_valid);

  // R5
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_use_reg && in_amount == '0 && in_kind <= SH_ROR |=>
      out_value == $past(in_operand) && out_carry == $past(in_carry) && !out_carry_valid);

  // R3
  wide_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_use_reg && in_amount > FULL && (in_kind == SH_LSL || in_kind == SH_LSR) |=>
      out_value == '0 && !out_carry && out_carry_valid);

  // R4
  asr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_use_reg && in_amount >= FULL && in_kind == SH_ASR |=>
      out_value == {WIDTH{$past(in_operand[WIDTH-1])}} &&
      out_carry == $past(in_operand[WIDTH-1]));
endmodule

// File: tb/sim_barrel_shift_unit.sv
`timescale 1ns/1ps
module sim_barrel_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_operand = '0;
  logic [2:0]  in_kind = '0;
  logic [7:0]  in_amount = '0;
  logic        in_use_reg = 1'b0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_value;
  logic        out_carry;
  logic        out_carry_valid;

  always #4 clk = ~clk;

  barrel_shift_unit u0 (.*);

  typedef struct {
    logic [31:0] v;
    logic        c;
    logic        cv;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  // Step-by-step reference: one bit per iteration.
  function automatic exp_t model(logic [31:0] a, logic [2:0] k, logic [7:0] amt,
                                 logic ureg, logic cin);
    exp_t e;
    int n;
    logic [31:0] v;
    logic c;
    bit keep;
    v = a; c = cin; keep = 0;
    n = ureg ? int'(amt) : int'(amt[4:0]);
    if (k == 3'd4) begin
      e.v = {cin, a[31:1]}; e.c = a[0]; e.cv = 1'b1; return e;
    end
    if (!ureg && n == 0) begin
      if (k == 3'd1 || k == 3'd2) n = 32; else keep = 1;
    end
    if (ureg && n == 0) keep = 1;
    if (keep) begin
      e.v = a; e.c = cin; e.cv = 1'b0; return e;
    end
    if (k == 3'd3) begin
      if (n % 32 == 0) c = a[31];
      for (int i = 0; i < n % 32; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
    end else begin
      for (int i = 0; i < n; i++) begin
        case (k)
          3'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
          3'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
          default: begin c = v[0]; v = {v[31], v[31:1]}; end
        endcase
      end
    end
    e.v = v; e.c = c; e.cv = 1'b1;
    return e;
  endfunction

  task automatic send(logic [31:0] a, logic [2:0] k, logic [7:0] amt, logic ureg,
                      logic cin, string tag);
    exp_t e;
    @(negedge clk);
    in_operand = a; in_kind = k; in_amount = amt; in_use_reg = ureg; in_carry = cin;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    e = model(a, k, amt, ureg, cin);
    e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #2 out_ready = stall_en ? ($urandom % 4 != 0) : 1'b1;
  end

  // Monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected result %h, expected none", out_value);
      end else begin
        e = sb.pop_front();
        if (out_value !== e.v || out_carry !== e.c || out_carry_valid !== e.cv) begin
          errors++;
          $display("FAIL %s: got v=%h c=%b cv=%b expected v=%h c=%b cv=%b",
                   e.tag, out_value, out_carry, out_carry_valid, e.v, e.c, e.cv);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12: after reset out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end

    // R1 left shifts
    send(32'h8000_0001, 3'd0, 8'd1,  1'b1, 1'b0, "R1");
    send(32'h4000_0000, 3'd0, 8'd2,  1'b0, 1'b0, "R1");
    send(32'h0000_0003, 3'd0, 8'd31, 1'b1, 1'b0, "R1");
    // R2 right shifts and rotates
    send(32'h0000_0001, 3'd1, 8'd1,  1'b1, 1'b0, "R2");
    send(32'h8000_00F0, 3'd2, 8'd5,  1'b0, 1'b0, "R2");
    send(32'h1234_5678, 3'd3, 8'd8,  1'b1, 1'b0, "R2");
    send(32'hC000_0000, 3'd1, 8'd31, 1'b0, 1'b1, "R2");
    // R3 exactly 32 and above
    send(32'h0000_0001, 3'd0, 8'd32, 1'b1, 1'b0, "R3");
    send(32'h8000_0000, 3'd1, 8'd32, 1'b1, 1'b0, "R3");
    send(32'hFFFF_FFFF, 3'd0, 8'd33, 1'b1, 1'b1, "R3");
    send(32'hFFFF_FFFF, 3'd1, 8'd255, 1'b1, 1'b1, "R3");
    // R4 arithmetic fill
    send(32'h8000_0000, 3'd2, 8'd32, 1'b1, 1'b0, "R4");
    send(32'h7FFF_FFFF, 3'd2, 8'd200, 1'b1, 1'b1, "R4");
    // R5 register zero
    send(32'hDEAD_BEEF, 3'd0, 8'd0, 1'b1, 1'b1, "R5");
    send(32'hDEAD_BEEF, 3'd2, 8'd0, 1'b1, 1'b0, "R5");
    send(32'hDEAD_BEEF, 3'd3, 8'd0, 1'b1, 1'b1, "R5");
    // R6 rotate by multiples of 32
    send(32'h8000_0001, 3'd3, 8'd32, 1'b1, 1'b0, "R6");
    send(32'h7000_0001, 3'd3, 8'd64, 1'b1, 1'b1, "R6");
    // R7 rotate uses low five bits
    send(32'h0000_00F1, 3'd3, 8'd36, 1'b1, 1'b0, "R7");
    send(32'hA5A5_0F0F, 3'd3, 8'd255, 1'b1, 1'b0, "R7");
    // R8 rotate through carry
    send(32'h0000_0003, 3'd4, 8'd9, 1'b1, 1'b1, "R8");
    send(32'h8000_0000, 3'd4, 8'd0, 1'b0, 1'b0, "R8");
    // R9 immediate forms
    send(32'h8000_0000, 3'd1, 8'd0,  1'b0, 1'b0, "R9");
    send(32'h8123_0000, 3'd2, 8'd0,  1'b0, 1'b0, "R9");
    send(32'h0000_0100, 3'd1, 8'hE9, 1'b0, 1'b0, "R9");
    // R10 immediate zero holds
    send(32'h1357_9BDF, 3'd0, 8'd0,  1'b0, 1'b1, "R10");
    send(32'h1357_9BDF, 3'd3, 8'd32, 1'b0, 1'b0, "R10");

    // R11 random traffic under back-pressure
    stall_en = 1'b1;
    for (int i = 0; i < 600; i++) begin
      logic [7:0] amt;
      amt = (i % 3 == 0) ? 8'($urandom % 40) : 8'($urandom);
      send($urandom, 3'($urandom % 5), amt, 1'($urandom), 1'($urandom), "R11");
    end
    @(negedge clk);
    in_valid = 1'b0;
    stall_en = 1'b0;
    repeat (20) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d results missing, expected 0", sb.size());
    end
    finish_run();
  end
endmodule